// File: doc/BRIEF.md
# Character Display Command Controller

This block is the command side of a character display controller, as seen from an 8-bit parallel host port. Each access is one cycle of the synchronous `stb` strobe, qualified by a register-select line (`rs`) and a direction line (`rw`). With `rs` low, a write goes to the instruction decoder and a read returns status. With `rs` high, the host writes or reads the character memories. Two memories sit inside the block: an 80-byte display memory of character codes and a 64-byte glyph pattern memory. A single address counter serves both. It steps up or down after every data access, and the most recent address-set instruction decides which memory it points into.

Every accepted instruction or data access starts an execution window, and a busy flag is raised for its length. The length is converted from real time to clock cycles using the `CLK_KHZ` parameter: 1.53 ms for clear and home, 39 µs for other instructions, and 43 µs for data accesses. While the flag is up, only status reads are served. The display mode bits and a display scroll offset are held in registers and driven onto output pins for the scan logic that follows this block.

Top module: `lcdc_top`

## Requirements
- R1: After reset, `busy`, `dout`, `disp_on`, `cursor_on`, `blink_on`, `shift_mode`, `two_line`, `tall_font` and `disp_ofs` are 0, while `inc_mode` and `bus8` are 1.
- R2: A status read (`stb` with `rs`=0, `rw`=1) is served even while busy and starts no busy window. After the next clock edge, `dout` holds the busy flag as it was at that edge in bit 7 and the address counter in bits 6..0.
- R3: The highest set bit of an instruction selects its class. 0x01 is clear. 0b0000001x is home. 0b000001IS is entry mode (I→`inc_mode`, S→`shift_mode`). 0b00001DCB is display control (D→`disp_on`, C→`cursor_on`, B→`blink_on`). 0b0001MRxx is shift. 0b001LNFxx is function set (L→`bus8`, N→`two_line`, F→`tall_font`). 0b01aaaaaa sets a pattern address. 0b1aaaaaaa sets a display address.
- R4: A data write stores `din` at the address counter, and the counter then steps +1 when `inc_mode`=1 or −1 when it is 0. Display addresses wrap between 79 and 0, and pattern addresses wrap between 63 and 0.
- R5: A data read sets `dout` to the byte at the address counter after the next clock edge, and the counter then steps as in R4.
- R6: A pattern-address instruction loads bits 5..0 and directs data accesses to the pattern memory. A display-address instruction directs them to the display memory, and a 7-bit value of 80 or more is loaded as the value minus 80.
- R7: Clear writes 0x20 into all 80 display bytes and sets the address counter and `disp_ofs` to 0, with the display memory selected.
- R8: Home sets the address counter and `disp_ofs` to 0 and selects the display memory, leaving both memories unchanged.
- R9: From the clock edge that accepts an access, `busy` stays high for exactly LONG cycles after clear or home, SHORT cycles after any other instruction and DATA cycles after a data access. These are 1530, 39 and 43 cycles at `CLK_KHZ`=1000.
- R10: While `busy`=1, instruction writes, data writes and data reads are ignored. They change neither memory, the address counter nor any mode output.
- R11: A shift instruction with M=1 moves `disp_ofs` by +1 when R=0 or −1 when R=1, wrapping within 0..79. With M=0, it steps the address counter +1 when R=1 or −1 when R=0.
- R12: When `shift_mode`=1, each display-memory data write also moves `disp_ofs` by +1 if `inc_mode`=1 or −1 if it is 0. Pattern-memory writes leave `disp_ofs` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stb | input | 1 | Access strobe, one access per high cycle |
| rs | input | 1 | 0: instruction/status, 1: memory data |
| rw | input | 1 | 0: write, 1: read |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data (status or memory byte) |
| busy | output | 1 | Execution window in progress |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Cursor blink enable |
| inc_mode | output | 1 | Address step direction, 1 = increment |
| shift_mode | output | 1 | Scroll display on data write |
| bus8 | output | 1 | 8-bit host bus selected |
| two_line | output | 1 | Two-line display selected |
| tall_font | output | 1 | 5x10 glyph font selected |
| disp_ofs | output | 7 | Display scroll offset, 0..79 |

## Verification
The bench builds the block with `CLK_KHZ`=1000, which turns the execution windows into 1530, 39 and 43 cycles. At that scale the bench can count the busy length of each access class exactly. It can also afford to read back all 80 display bytes after a clear, and it can fill the whole pattern memory. With the memories left at their default depths of 80 and 64, the counter wraps at 79 and at 63 are reached directly, as is the folding of address values above 79. A fixed-seed random mix of accesses follows, and it drives the offset and counter through many wrap-arounds in both directions.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_CLEAR, CMD_HOME, CMD_ENTRY, CMD_DISP,
    CMD_SHIFT, CMD_FUNC, CMD_CGADDR, CMD_DDADDR
  } cmd_e;

  // class is chosen by the highest set bit of the code
  function automatic cmd_e classify(input logic [7:0] c);
    if (c[7])      return CMD_DDADDR;
    else if (c[6]) return CMD_CGADDR;
    else if (c[5]) return CMD_FUNC;
    else if (c[4]) return CMD_SHIFT;
    else if (c[3]) return CMD_DISP;
    else if (c[2]) return CMD_ENTRY;
    else if (c[1]) return CMD_HOME;
    else if (c[0]) return CMD_CLEAR;
    else           return CMD_NONE;
  endfunction

endpackage

// File: rtl/lcdc_sp_ram.sv
module lcdc_sp_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 80,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/lcdc_busy_timer.sv
module lcdc_busy_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= len;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

  assert_busy_ends_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cnt) == CW'(1)));
endmodule

// File: rtl/lcdc_addr_unit.sv
module lcdc_addr_unit #(
  parameter int AW       = 7,
  parameter int DD_DEPTH = 80,
  parameter int CG_AW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zero,
  input  logic          set_dd,
  input  logic          set_cg,
  input  logic [AW-1:0] val,
  input  logic          step,
  input  logic          up,
  output logic [AW-1:0] ac,
  output logic          cg_sel
);
  localparam logic [AW-1:0] DD_LAST = AW'(DD_DEPTH - 1);
  localparam logic [AW-1:0] DD_SPAN = AW'(DD_DEPTH);

  logic [CG_AW-1:0] cg_next;
  logic [AW-1:0]    dd_next;
  logic [AW-1:0]    dd_fold;

  always_comb begin
    cg_next = up ? ac[CG_AW-1:0] + CG_AW'(1) : ac[CG_AW-1:0] - CG_AW'(1);
    if (up) dd_next = (ac == DD_LAST) ? '0 : ac + AW'(1);
    else    dd_next = (ac == '0) ? DD_LAST : ac - AW'(1);
    dd_fold = (val >= DD_SPAN) ? val - DD_SPAN : val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ac     <= '0;
      cg_sel <= 1'b0;
    end else if (zero) begin
      ac     <= '0;
      cg_sel <= 1'b0;
    end else if (set_dd) begin
      ac     <= dd_fold;
      cg_sel <= 1'b0;
    end else if (set_cg) begin
      ac     <= {{(AW-CG_AW){1'b0}}, val[CG_AW-1:0]};
      cg_sel <= 1'b1;
    end else if (step) begin
      ac     <= cg_sel ? {{(AW-CG_AW){1'b0}}, cg_next} : dd_next;
    end
  end

  assert_dd_range_R4: assert property (@(posedge clk) disable iff (rst)
    !cg_sel |-> (ac < DD_SPAN));
  assert_cg_range_R6: assert property (@(posedge clk) disable iff (rst)
    cg_sel |-> (ac[AW-1:CG_AW] == '0));
endmodule

// File: rtl/lcdc_top.sv
module lcdc_top #(
  parameter int CLK_KHZ  = 50000,
  parameter int DD_DEPTH = 80,
  parameter int CG_DEPTH = 64,
  parameter int DW       = 8,
  parameter int LONG_NS  = 1530000,
  parameter int SHORT_NS = 39000,
  parameter int DATA_NS  = 43000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic          rs,
  input  logic          rw,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          busy,
  output logic          disp_on,
  output logic          cursor_on,
  output logic          blink_on,
  output logic          inc_mode,
  output logic          shift_mode,
  output logic          bus8,
  output logic          two_line,
  output logic          tall_font,
  output logic [$clog2(DD_DEPTH)-1:0] disp_ofs
);
  import lcdc_pkg::*;

  localparam int AW    = $clog2(DD_DEPTH);
  localparam int CG_AW = $clog2(CG_DEPTH);
  localparam longint LONG_L  = (longint'(CLK_KHZ) * longint'(LONG_NS))  / 64'd1000000;
  localparam longint SHORT_L = (longint'(CLK_KHZ) * longint'(SHORT_NS)) / 64'd1000000;
  localparam longint DATA_L  = (longint'(CLK_KHZ) * longint'(DATA_NS))  / 64'd1000000;
  localparam int LONG_C  = int'(LONG_L);
  localparam int SHORT_C = int'(SHORT_L);
  localparam int DATA_C  = int'(DATA_L);
  localparam int CW      = $clog2(LONG_C + 1);
  localparam logic [AW-1:0] DD_LAST = AW'(DD_DEPTH - 1);
  localparam logic [DW-1:0] BLANK   = DW'(8'h20);

  // access decode
  logic  is_status, go, go_instr, go_wr, go_rd;
  cmd_e  cmd;
  assign is_status = stb && !rs && rw;
  assign go        = stb && !busy && !is_status;
  assign go_instr  = go && !rs && !rw;
  assign go_wr     = go && rs && !rw;
  assign go_rd     = go && rs && rw;
  assign cmd       = classify(din[7:0]);

  logic to_zero, is_clear;
  assign is_clear = go_instr && (cmd == CMD_CLEAR);
  assign to_zero  = go_instr && ((cmd == CMD_CLEAR) || (cmd == CMD_HOME));

  // busy window
  logic [CW-1:0] len;
  always_comb begin
    if (go_instr) len = to_zero ? CW'(LONG_C) : CW'(SHORT_C);
    else          len = CW'(DATA_C);
  end

  lcdc_busy_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(go), .len(len), .busy(busy));

  // address counter
  logic [AW-1:0] ac;
  logic          cg_sel;
  logic          cur_move;
  assign cur_move = go_instr && (cmd == CMD_SHIFT) && !din[3];

  lcdc_addr_unit #(.AW(AW), .DD_DEPTH(DD_DEPTH), .CG_AW(CG_AW)) u_addr (
    .clk(clk), .rst(rst), .zero(to_zero),
    .set_dd(go_instr && (cmd == CMD_DDADDR)),
    .set_cg(go_instr && (cmd == CMD_CGADDR)),
    .val(din[AW-1:0]),
    .step(go_wr || go_rd || cur_move),
    .up(cur_move ? din[2] : inc_mode),
    .ac(ac), .cg_sel(cg_sel));

  // mode registers
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_on <= 1'b0; cursor_on <= 1'b0; blink_on <= 1'b0;
      inc_mode <= 1'b1; shift_mode <= 1'b0;
      bus8 <= 1'b1; two_line <= 1'b0; tall_font <= 1'b0;
    end else if (go_instr) begin
      case (cmd)
        CMD_ENTRY: begin inc_mode <= din[1]; shift_mode <= din[0]; end
        CMD_DISP:  begin disp_on <= din[2]; cursor_on <= din[1]; blink_on <= din[0]; end
        CMD_FUNC:  begin bus8 <= din[4]; two_line <= din[3]; tall_font <= din[2]; end
        default: ;
      endcase
    end
  end

  // display scroll offset
  function automatic logic [AW-1:0] ring(input logic [AW-1:0] v, input logic up);
    if (up) return (v == DD_LAST) ? '0 : v + AW'(1);
    else    return (v == '0) ? DD_LAST : v - AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || to_zero)
      disp_ofs <= '0;
    else if (go_instr && (cmd == CMD_SHIFT) && din[3])
      disp_ofs <= ring(disp_ofs, !din[2]);
    else if (go_wr && !cg_sel && shift_mode)
      disp_ofs <= ring(disp_ofs, inc_mode);
  end

  // clear fill sequencer
  logic          fill_act;
  logic [AW-1:0] fill_idx;
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_act <= 1'b0;
      fill_idx <= '0;
    end else if (is_clear) begin
      fill_act <= 1'b1;
      fill_idx <= '0;
    end else if (fill_act) begin
      if (fill_idx == DD_LAST) fill_act <= 1'b0;
      else                     fill_idx <= fill_idx + AW'(1);
    end
  end

  // memories
  logic [DW-1:0] dd_rd, cg_rd;

  lcdc_sp_ram #(.DW(DW), .DEPTH(DD_DEPTH), .AW(AW)) u_dd (
    .clk(clk),
    .we(fill_act || (go_wr && !cg_sel)),
    .re(go_rd && !cg_sel),
    .addr(fill_act ? fill_idx : ac),
    .wdata(fill_act ? BLANK : din),
    .rdata(dd_rd));

  lcdc_sp_ram #(.DW(DW), .DEPTH(CG_DEPTH), .AW(CG_AW)) u_cg (
    .clk(clk),
    .we(go_wr && cg_sel),
    .re(go_rd && cg_sel),
    .addr(ac[CG_AW-1:0]),
    .wdata(din),
    .rdata(cg_rd));

  // read data path
  logic [DW-1:0] stat_q;
  logic          src_ram_q, src_cg_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0; src_ram_q <= 1'b0; src_cg_q <= 1'b0;
    end else if (is_status) begin
      stat_q         <= DW'(ac);
      stat_q[DW-1]   <= busy;
      src_ram_q      <= 1'b0;
    end else if (go_rd) begin
      src_ram_q <= 1'b1;
      src_cg_q  <= cg_sel;
    end
  end

  assign dout = !src_ram_q ? stat_q : (src_cg_q ? cg_rd : dd_rd);

  // checks
  assert_status_R2: assert property (@(posedge clk) disable iff (rst)
    is_status |=> (dout == {$past(busy), $past(ac)}));
  assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
    go |=> busy);
  assert_hold_ac_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ac) && $stable(cg_sel));
  assert_hold_mode_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable({disp_on, cursor_on, blink_on, inc_mode, shift_mode,
                      bus8, two_line, tall_font, disp_ofs}));
  assert_fill_busy_R7: assert property (@(posedge clk) disable iff (rst)
    fill_act |-> busy);
endmodule

// File: tb/lcdc_top_test.sv
module lcdc_top_test;
  localparam int LONG_C = 1530, SHORT_C = 39, DATA_C = 43;

  logic clk = 1'b0, rst = 1'b1, stb = 1'b0, rs = 1'b0, rw = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic [6:0] disp_ofs;
  logic busy, disp_on, cursor_on, blink_on, inc_mode, shift_mode, bus8, two_line, tall_font;

  lcdc_top #(.CLK_KHZ(1000)) uut (
    .clk(clk), .rst(rst), .stb(stb), .rs(rs), .rw(rw), .din(din), .dout(dout),
    .busy(busy), .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on),
    .inc_mode(inc_mode), .shift_mode(shift_mode), .bus8(bus8), .two_line(two_line),
    .tall_font(tall_font), .disp_ofs(disp_ofs));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdd [80];
  logic [7:0] mcg [64];
  int mac = 0, mofs = 0;
  bit mcgs = 0, mid = 1, msh = 0;
  bit mdisp = 0, mcur = 0, mblk = 0, mdl = 1, mn = 0, mf = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ring(int v, bit up, int n);
    return up ? (v + 1) % n : (v + n - 1) % n;
  endfunction

  task automatic pulse(bit r, bit w, logic [7:0] d);
    @(negedge clk); rs = r; rw = w; din = d; stb = 1'b1;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  function automatic void model_step(bit up);
    if (mcgs) mac = ring(mac, up, 64);
    else      mac = ring(mac, up, 80);
  endfunction

  task automatic do_instr(logic [7:0] d, output int n);
    pulse(1'b0, 1'b0, d);
    count_busy(n);
    if (d[7])      begin mac = (d[6:0] >= 80) ? d[6:0] - 80 : d[6:0]; mcgs = 0; end
    else if (d[6]) begin mac = d[5:0]; mcgs = 1; end
    else if (d[5]) begin mdl = d[4]; mn = d[3]; mf = d[2]; end
    else if (d[4]) begin
      if (d[3]) mofs = ring(mofs, !d[2], 80);
      else      model_step(d[2]);
    end
    else if (d[3]) begin mdisp = d[2]; mcur = d[1]; mblk = d[0]; end
    else if (d[2]) begin mid = d[1]; msh = d[0]; end
    else if (d[1]) begin mac = 0; mofs = 0; mcgs = 0; end
    else if (d[0]) begin
      mac = 0; mofs = 0; mcgs = 0;
      for (int i = 0; i < 80; i++) mdd[i] = 8'h20;
    end
  endtask

  task automatic do_write(logic [7:0] d, output int n);
    pulse(1'b1, 1'b0, d);
    count_busy(n);
    if (mcgs) mcg[mac] = d;
    else begin
      mdd[mac] = d;
      if (msh) mofs = ring(mofs, mid, 80);
    end
    model_step(mid);
  endtask

  task automatic do_read(string req);
    int n;
    logic [7:0] e;
    e = mcgs ? mcg[mac] : mdd[mac];
    pulse(1'b1, 1'b1, 8'h00);
    check(req, dout, e);
    count_busy(n);
    model_step(mid);
  endtask

  task automatic status_check(string req, bit exp_busy);
    pulse(1'b0, 1'b1, 8'h00);
    check(req, dout, {exp_busy, 7'(mac)});
  endtask

  task automatic mode_check(string req);
    check(req, {disp_on, cursor_on, blink_on, inc_mode, shift_mode, bus8, two_line, tall_font},
          {mdisp, mcur, mblk, mid, msh, mdl, mn, mf});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, ref_loc;
    int unsigned r;
    r = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 dout", dout, 0);
    mode_check("R1 modes");
    check("R1 ofs", disp_ofs, 0);
    status_check("R2 idle status", 1'b0);
    check("R2 no busy after status", busy, 0);

    // R7 clear and R9 long window
    do_instr(8'h01, n);
    check("R9 clear length", n, LONG_C);
    status_check("R7 ac zero", 1'b0);
    for (int i = 0; i < 80; i++) do_read("R7 blank fill");
    status_check("R4 wrap 79 to 0 on reads", 1'b0);

    // R3 class decode and R9 short window
    do_instr(8'h38, n);
    check("R9 instr length", n, SHORT_C);
    mode_check("R3 function set 38");
    do_instr(8'h2C, n); mode_check("R3 function set 2C");
    do_instr(8'h0F, n); mode_check("R3 display 0F");
    do_instr(8'h0A, n); mode_check("R3 display 0A");
    do_instr(8'h00, n); check("R9 null instr length", n, SHORT_C);
    mode_check("R3 null code no change");

    // R6 pattern memory, R4 pattern wrap
    do_instr(8'h40, n);
    for (int i = 0; i < 64; i++) begin
      do_write(8'((i * 7) + 3), n);
      if (i == 0) check("R9 data length", n, DATA_C);
    end
    status_check("R4 pattern wrap 63 to 0", 1'b0);
    do_instr(8'h7E, n);
    status_check("R6 pattern address", 1'b0);
    do_read("R5 pattern read");
    do_read("R5 pattern read wrap");
    status_check("R4 pattern ac after reads", 1'b0);

    // R6 display address fold
    do_instr(8'hD0, n); status_check("R6 fold 80", 1'b0);
    do_instr(8'hFF, n); status_check("R6 fold 127", 1'b0);
    do_instr(8'hC5, n); status_check("R6 keep 69", 1'b0);

    // R4 display wrap both ways
    do_instr(8'hCF, n);
    do_write(8'h41, n);
    status_check("R4 write wrap 79 to 0", 1'b0);
    do_instr(8'h04, n);
    do_write(8'h42, n);
    status_check("R4 write wrap 0 to 79", 1'b0);
    do_instr(8'h06, n);

    // R10 accesses during busy are ignored
    do_instr(8'h8A, n);
    ref_loc = mac;
    pulse(1'b1, 1'b0, 8'hA5);
    mdd[mac] = 8'hA5; model_step(mid);
    pulse(1'b1, 1'b0, 8'h5A);
    pulse(1'b0, 1'b0, 8'h0C);
    pulse(1'b1, 1'b1, 8'h00);
    status_check("R2 status while busy", 1'b1);
    count_busy(n);
    status_check("R10 ac after ignored", 1'b0);
    mode_check("R10 modes after ignored");
    do_instr(8'h80 | 8'(ref_loc), n);
    do_read("R10 first write kept");
    do_read("R10 next byte untouched");

    // R11 shift instruction
    do_instr(8'h18, n); check("R11 display left", disp_ofs, mofs);
    do_instr(8'h1C, n); check("R11 display right", disp_ofs, mofs);
    do_instr(8'h1C, n); check("R11 display right wrap", disp_ofs, 79);
    do_instr(8'h14, n); status_check("R11 cursor right", 1'b0);
    do_instr(8'h10, n); status_check("R11 cursor left", 1'b0);

    // R12 entry shift
    do_instr(8'h07, n);
    do_write(8'h61, n); check("R12 shift inc", disp_ofs, mofs);
    do_write(8'h62, n); check("R12 shift inc 2", disp_ofs, 1);
    do_instr(8'h05, n);
    do_write(8'h63, n); check("R12 shift dec", disp_ofs, mofs);
    do_instr(8'h41, n);
    do_write(8'h64, n); check("R12 pattern write no shift", disp_ofs, mofs);

    // R8 home
    do_instr(8'h03, n);
    check("R9 home length", n, LONG_C);
    check("R8 ofs zero", disp_ofs, 0);
    status_check("R8 ac zero", 1'b0);
    do_instr(8'h06, n);
    do_read("R8 memory kept");

    // random mix
    for (int k = 0; k < 260; k++) begin
      r = $urandom % 8;
      case (r)
        0, 1: do_write(8'($urandom), n);
        2, 3: do_read("R5 random read");
        4:    do_instr(8'h80 | 8'($urandom % 128), n);
        5:    do_instr(8'h40 | 8'($urandom % 64), n);
        6:    do_instr(8'h04 | 8'($urandom % 4), n);
        default: do_instr(8'h10 | 8'(($urandom % 4) << 2), n);
      endcase
      check("R12 random ofs", disp_ofs, mofs);
      if (k % 8 == 0) status_check("R4 random ac", 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule